// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Round-Robin Selection

This block collects a vector of interrupt request lines, 32 or 64 of them depending on a parameter, and qualifies each line with a per-source enable bit held in a mask register. The qualified vector is called the pending vector. A round-robin selector picks one pending source and presents it to the consumer. The selector starts its search at a saved pointer. When the consumer acknowledges a selection, the pointer moves to the position just past the serviced source, so that no source can starve the others.

A contiguous window of source indices can be marked as belonging to external request lines, which cascade through this block. When cascading is enabled and the selected source falls inside that window, the block reports the source's offset within the window and raises an external flag. Any other source is reported by its own index.

Software reaches the block through a simple register port. This port reads the raw status, the mask and the pending vector. It writes the whole mask at once, or sets or clears a single mask bit without touching the others.

Top module: `irq_rr_aggregator`

## Requirements
- R1: The pending vector equals `irq_raw & mask`. A source whose mask bit is 0 is never selected. Reads at register address 0 return `irq_raw`, and reads at address 2 return the pending vector.
- R2: `NUM_SRC` is 32 or 64, and the pointer has log2(`NUM_SRC`) bits. After source `NUM_SRC-1` is serviced, the search continues from index 0.
- R3: The search starts at the pointer and walks upward, wrapping at the top. It selects the first pending index it finds. When `sel_ack` is high while `sel_valid` is high, the pointer becomes the selected index plus one, so the next selection is the first pending source after the serviced one.
- R4: While the pending vector is all zeros, `sel_valid` is 0 and the pointer does not change. An `sel_ack` that arrives while `sel_valid` is 0 is ignored.
- R5: With `CASCADE_EN`=1, a selected index `i` in the range `EXT_START` to `EXT_START+EXT_COUNT-1` is reported as `sel_num = i - EXT_START` with `sel_ext = 1`. `EXT_COUNT` is 4 or 6. Every other selected index is reported as `sel_num = i` with `sel_ext = 0`.
- R6: A write to address 1 loads the whole mask from `reg_wdata`. A write to address 2 sets the mask bit numbered by the low log2(`NUM_SRC`) bits of `reg_wdata`. A write to address 3 clears that bit. Neither single-bit write disturbs any other mask bit, and a read at address 1 returns the current mask.
- R7: The outputs `sel_valid`, `sel_num` and `sel_ext` are registered and reflect the mask, raw status and pointer of the previous cycle. While `sel_ack` stays low and the inputs hold, the selection does not change.
- R8: Synchronous active-high reset clears the mask to 0, sets the pointer to 0 and drives `sel_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | NUM_SRC | Raw interrupt request status, one bit per source |
| sel_ack | input | 1 | One-cycle acknowledge of the current selection |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 mask, 2 set bit or pending, 3 clear bit |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Register read data, combinational on `reg_addr` |
| sel_valid | output | 1 | A pending source is selected |
| sel_num | output | log2(NUM_SRC) | Internal index, or external number when `sel_ext` is 1 |
| sel_ext | output | 1 | The selection lies in the cascaded external window |

## Verification
The assertions check four properties on every cycle. A reported selection was pending one cycle earlier. An empty pending vector yields no selection. The pointer moves only on an acknowledged valid selection. An external report always lies within the window's count. The assertions also confirm that single-bit mask writes take effect. The bench scenarios are needed to show the actual rotation order and the wrap from the top index to zero. They also show that the pointer survives a period with nothing pending, and where the window's edges fall: the first and last external index against their internal neighbours.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Register port addresses
    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,   // read raw status
        RA_MASK   = 2'd1,   // read/write whole mask
        RA_SET    = 2'd2,   // write: set one bit; read: pending
        RA_CLR    = 2'd3    // write: clear one bit; read: zero
    } reg_addr_e;

    localparam int SEL_W_MAX = 6;

    // Registered selection presented to the consumer
    typedef struct packed {
        logic                 valid;
        logic                 ext;
        logic [SEL_W_MAX-1:0] num;
        logic [SEL_W_MAX-1:0] idx;
    } sel_out_t;

    function automatic int idx_bits(input int n);
        return (n > 32) ? 6 : 5;
    endfunction

endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int IW      = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  reg_addr_e          addr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] mask
);

    logic [NUM_SRC-1:0] mask_q;
    logic [IW-1:0]      bit_sel;

    assign bit_sel = wdata[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr) begin
            case (addr)
                RA_MASK: mask_q          <= wdata;
                RA_SET:  mask_q[bit_sel] <= 1'b1;
                RA_CLR:  mask_q[bit_sel] <= 1'b0;
                default: ;
            endcase
        end
    end

    assign mask = mask_q;

    // R6: a single-bit set takes effect on the next cycle
    assert_set_bit_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == RA_SET) |=> mask_q[$past(bit_sel)]);

    // R6: a single-bit clear takes effect on the next cycle
    assert_clr_bit_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == RA_CLR) |=> !mask_q[$past(bit_sel)]);

endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
    parameter int NUM_SRC = 32,
    parameter int IW      = 5
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [IW-1:0]      start,
    output logic               found,
    output logic [IW-1:0]      idx
);

    // Cyclic scan from start upward; first pending index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            int p;
            p = (int'(start) + k) % NUM_SRC;
            if (!found && pend[p]) begin
                found = 1'b1;
                idx   = IW'(p);
            end
        end
    end

endmodule

// File: rtl/irq_cascade_map.sv
module irq_cascade_map #(
    parameter int IW         = 5,
    parameter bit CASCADE_EN = 1'b1,
    parameter int EXT_START  = 8,
    parameter int EXT_COUNT  = 4
) (
    input  logic [IW-1:0] idx,
    output logic [IW-1:0] num,
    output logic          ext
);

    localparam int EXT_END = EXT_START + EXT_COUNT - 1;

    logic in_win;

    generate
        if (CASCADE_EN) begin : g_casc
            assign in_win = (int'(idx) >= EXT_START) && (int'(idx) <= EXT_END);
        end else begin : g_flat
            assign in_win = 1'b0;
        end
    endgenerate

    always_comb begin
        ext = in_win;
        num = in_win ? IW'(int'(idx) - EXT_START) : idx;
    end

endmodule

// File: rtl/irq_rr_aggregator.sv
module irq_rr_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC    = 32,
    parameter bit CASCADE_EN = 1'b1,
    parameter int EXT_START  = 8,
    parameter int EXT_COUNT  = 4,
    localparam int IW        = idx_bits(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_raw,
    input  logic               sel_ack,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               sel_valid,
    output logic [IW-1:0]      sel_num,
    output logic               sel_ext
);

    reg_addr_e          addr_e;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] pending;
    logic [IW-1:0]      ptr_q, ptr_d;
    logic               pick_found;
    logic [IW-1:0]      pick_idx;
    logic [IW-1:0]      map_num;
    logic               map_ext;
    sel_out_t           out_q;
    logic               take;

    assign addr_e  = reg_addr_e'(reg_addr);
    assign pending = irq_raw & mask;

    irq_mask_bank #(.NUM_SRC(NUM_SRC), .IW(IW)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (addr_e),
        .wdata (reg_wdata),
        .mask  (mask)
    );

    // Pointer moves just past the serviced index on an accepted ack.
    // NUM_SRC is a power of two, so the IW-bit increment wraps naturally.
    assign take  = sel_ack && out_q.valid;
    assign ptr_d = take ? (out_q.idx[IW-1:0] + 1'b1) : ptr_q;

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    // Search from the next pointer so the output is consistent after an ack.
    irq_rr_pick #(.NUM_SRC(NUM_SRC), .IW(IW)) u_pick (
        .pend  (pending),
        .start (ptr_d),
        .found (pick_found),
        .idx   (pick_idx)
    );

    irq_cascade_map #(
        .IW(IW), .CASCADE_EN(CASCADE_EN),
        .EXT_START(EXT_START), .EXT_COUNT(EXT_COUNT)
    ) u_map (
        .idx (pick_idx),
        .num (map_num),
        .ext (map_ext)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= pick_found;
            out_q.ext   <= pick_found && map_ext;
            out_q.num   <= SEL_W_MAX'(map_num);
            out_q.idx   <= SEL_W_MAX'(pick_idx);
        end
    end

    assign sel_valid = out_q.valid;
    assign sel_num   = out_q.num[IW-1:0];
    assign sel_ext   = out_q.ext;

    always_comb begin
        case (addr_e)
            RA_STATUS: reg_rdata = irq_raw;
            RA_MASK:   reg_rdata = mask;
            RA_SET:    reg_rdata = pending;
            default:   reg_rdata = '0;
        endcase
    end

    // R1: a reported source was pending in the cycle it was chosen
    assert_sel_pending_R1: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> |($past(pending) & (NUM_SRC'(1) << out_q.idx[IW-1:0])));

    // R4: nothing pending means nothing reported next cycle
    assert_empty_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (pending == '0) |=> !sel_valid);

    // R7 / R4: pointer holds without an accepted acknowledge
    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!sel_ack || !sel_valid) |=> $stable(ptr_q));

    // R3: with several sources pending, an ack moves to a different source
    assert_rr_moves_R3: assert property (@(posedge clk) disable iff (rst)
        (sel_ack && sel_valid && $countones(pending) > 1)
        |=> (out_q.idx != $past(out_q.idx)));

    // R5: an external report always lies inside the window
    assert_ext_range_R5: assert property (@(posedge clk) disable iff (rst)
        sel_ext |-> (CASCADE_EN && sel_valid && int'(sel_num) < EXT_COUNT));

endmodule

// File: tb/sim_irq_rr_aggregator.sv
module sim_irq_rr_aggregator;

    localparam int N  = 32;
    localparam int IW = 5;
    localparam int ES = 8;
    localparam int EC = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  irq_raw;
    logic          sel_ack;
    logic          reg_wr;
    logic [1:0]    reg_addr;
    logic [N-1:0]  reg_wdata;
    logic [N-1:0]  reg_rdata;
    logic          sel_valid;
    logic [IW-1:0] sel_num;
    logic          sel_ext;

    int n_chk  = 0;
    int n_fail = 0;

    logic [N-1:0]  m_mask;
    logic [IW-1:0] m_ptr;

    always #5 clk = ~clk;

    irq_rr_aggregator #(.NUM_SRC(N), .CASCADE_EN(1'b1), .EXT_START(ES), .EXT_COUNT(EC)) u0 (
        .clk(clk), .rst(rst), .irq_raw(irq_raw), .sel_ack(sel_ack),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sel_valid(sel_valid), .sel_num(sel_num),
        .sel_ext(sel_ext)
    );

    task automatic check_val(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Cyclic search model from the requirement text (R2, R3)
    task automatic model_pick(output logic v, output logic [IW-1:0] idx);
        logic [N-1:0] pend;
        pend = irq_raw & m_mask;
        v = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            int p;
            p = (int'(m_ptr) + k) % N;
            if (!v && pend[p]) begin
                v = 1'b1;
                idx = IW'(p);
            end
        end
    endtask

    task automatic check_sel(input string tag);
        logic v;
        logic [IW-1:0] idx;
        logic [IW-1:0] en;
        logic ee;
        model_pick(v, idx);
        ee = (int'(idx) >= ES) && (int'(idx) <= ES + EC - 1);
        en = ee ? IW'(int'(idx) - ES) : idx;
        check_val({tag, " valid"}, 64'(sel_valid), 64'(v));
        if (v) begin
            check_val({tag, " num"}, 64'(sel_num), 64'(en));
            check_val({tag, " ext"}, 64'(sel_ext), 64'(ee));
        end
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [N-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            2'd1: m_mask = d;
            2'd2: m_mask[d[IW-1:0]] = 1'b1;
            2'd3: m_mask[d[IW-1:0]] = 1'b0;
            default: ;
        endcase
        idle();
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_ack();
        logic v;
        logic [IW-1:0] idx;
        model_pick(v, idx);
        sel_ack = 1'b1;
        @(posedge clk);
        if (v) m_ptr = idx + 1'b1;
        @(negedge clk);
        sel_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [N-1:0] d;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_mask = '0; m_ptr = '0;
        irq_raw = '1;
        idle();
        check_val("R8 valid after reset", 64'(sel_valid), 64'd0);
        reg_read(2'd1, d);
        check_val("R8 mask after reset", 64'(d), 64'd0);
    endtask

    task automatic t_mask_ops();
        logic [N-1:0] d;
        irq_raw = '0;
        reg_write(2'd1, 32'h0000_00F0);
        reg_read(2'd1, d); check_val("R6 whole write", 64'(d), 64'hF0);
        reg_write(2'd2, 32'd2);
        reg_read(2'd1, d); check_val("R6 set bit 2", 64'(d), 64'hF4);
        reg_write(2'd3, 32'd5);
        reg_read(2'd1, d); check_val("R6 clear bit 5", 64'(d), 64'hD4);
        reg_write(2'd2, 32'd4);
        reg_read(2'd1, d); check_val("R6 set already set", 64'(d), 64'hD4);
    endtask

    task automatic t_pending();
        logic [N-1:0] d;
        irq_raw = 32'hFFFF_0000;
        idle();
        reg_read(2'd2, d); check_val("R1 pending disjoint", 64'(d), 64'd0);
        check_val("R1 masked not selected", 64'(sel_valid), 64'd0);
        irq_raw = 32'h0000_0014;
        idle();
        reg_read(2'd0, d); check_val("R1 status read", 64'(d), 64'h14);
        reg_read(2'd2, d); check_val("R1 pending read", 64'(d), 64'h14);
        check_sel("R1 pick from pending");
        check_val("R1 selected index", 64'(sel_num), 64'd2);
    endtask

    task automatic t_round_robin();
        irq_raw = '1;
        reg_write(2'd1, 32'h0010_0204);
        check_val("R3 first pick", 64'(sel_num), 64'd2);
        pulse_ack();
        check_sel("R3 after ack 1");
        check_val("R5 index 9 external num", 64'(sel_num), 64'd1);
        check_val("R5 index 9 flag", 64'(sel_ext), 64'd1);
        pulse_ack();
        check_sel("R3 after ack 2");
        check_val("R3 index 20", 64'(sel_num), 64'd20);
        pulse_ack();
        check_sel("R3 wrap to 2");
        check_val("R3 back to 2", 64'(sel_num), 64'd2);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 3; i++) begin
            idle();
            check_sel("R7 hold without ack");
            check_val("R7 stable index", 64'(sel_num), 64'd2);
        end
    endtask

    task automatic t_wrap();
        pulse_ack();   // service 2, pointer to 3
        reg_write(2'd1, 32'h8000_0001);
        check_sel("R2 pick top");
        check_val("R2 top index", 64'(sel_num), 64'd31);
        pulse_ack();
        check_sel("R2 wrap to zero");
        check_val("R2 index 0", 64'(sel_num), 64'd0);
        pulse_ack();
        check_val("R2 back to top", 64'(sel_num), 64'd31);
    endtask

    task automatic t_empty();
        irq_raw = '0;
        idle();
        check_val("R4 nothing pending", 64'(sel_valid), 64'd0);
        pulse_ack();
        pulse_ack();
        check_val("R4 ack ignored", 64'(sel_valid), 64'd0);
        irq_raw = '1;
        reg_write(2'd1, 32'h8000_0021);
        check_sel("R4 pointer kept");
        check_val("R4 resumes at 5", 64'(sel_num), 64'd5);
    endtask

    task automatic t_ext_bounds();
        reg_write(2'd1, 32'h0000_0800);
        check_val("R5 index 11 num", 64'(sel_num), 64'd3);
        check_val("R5 index 11 ext", 64'(sel_ext), 64'd1);
        reg_write(2'd1, 32'h0000_1000);
        check_val("R5 index 12 num", 64'(sel_num), 64'd12);
        check_val("R5 index 12 ext", 64'(sel_ext), 64'd0);
        reg_write(2'd1, 32'h0000_0080);
        check_val("R5 index 7 num", 64'(sel_num), 64'd7);
        check_val("R5 index 7 ext", 64'(sel_ext), 64'd0);
        reg_write(2'd1, 32'h0000_0100);
        check_val("R5 index 8 num", 64'(sel_num), 64'd0);
        check_val("R5 index 8 ext", 64'(sel_ext), 64'd1);
        irq_raw = 32'h0000_0800;
        reg_write(2'd1, 32'h0000_1000);
        check_val("R1 raw without mask", 64'(sel_valid), 64'd0);
    endtask

    initial begin
        rst = 1'b1; irq_raw = '0; sel_ack = 1'b0;
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        m_mask = '0; m_ptr = '0;
        @(negedge clk);
        t_reset();
        t_mask_ops();
        t_pending();
        t_round_robin();
        t_hold();
        t_wrap();
        t_empty();
        t_ext_bounds();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule